// File: doc/BRIEF.md
# Gated Multiplexed Two-Stage Clock Divider

This block produces the functional clock for one peripheral. A single 32-bit configuration word holds four fields: an enable, a parent select, a power-of-two prescale exponent and an integer divide count. Four parent clocks enter on one vector port. The selected parent is first divided by 1, 2, 4 or 8 and then by a count from 1 to 16. The result leaves through a glitch-safe gate. The block can only divide, so the output never runs faster than its selected parent.

Software reaches the word through a simple bus port. The port has an address, a write strobe, write data and combinational read data. A write takes effect at the next rising edge of the bus clock. Switching between asynchronous parents is kept simple. A new select value reaches the clock mux only while the enable bit is clear. New divide values are synchronised into the parent domain and loaded at the end of the current output period, so no shortened high phase appears. When both divide fields are zero, the selected parent passes straight through the gate.

Top module: `cdiv_top`

## Requirements
- R1: The configuration word sits at bus address REG_ADDR (default 0). Bit 31 is the enable, bits 25:24 the parent select, bits 17:16 the prescale exponent p, and bits 3:0 the divide count m. A read returns these bits, all other bits read as 0, and writing 0xFFFFFFFF reads back 0x8303000F.
- R2: While enabled, clk_out has exactly one rising edge per (m+1)*2^p rising edges of the selected parent.
- R3: While the enable bit is 0, clk_out and clk_on stay low.
- R4: Select value i routes par_clk[i] to the divider.
- R5: While the stored enable is 1, a write to the select field does not change the parent in use. The new select is applied once the enable is cleared.
- R6: With m = 0 and p = 0, clk_out follows the selected parent, giving one output edge per parent edge.
- R7: A divider change made while running is loaded only at a terminal count, and the m-stage counter never exceeds the loaded m. After the change has settled, the new ratio holds.
- R8: After reset the word reads 0 and clk_out and clk_on are low.
- R9: A write to any address other than REG_ADDR leaves the word unchanged, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Clock for the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| par_clk | input | 4 | Parent clocks, index equals select value |
| clk_out | output | 1 | Gated, divided clock |
| clk_on | output | 1 | High while the gate is open |

## Verification
Register effects appear on bus_rdata as soon as the bus clock edge after the write strobe has passed, so the bench reads one bus cycle later. The enable and the divide fields pass through two parent-clock synchronising flops before the divider uses them. A new ratio is loaded only at a terminal count. For these reasons the bench waits at least 2*(m+1)*2^p + 8 edges of the selected parent after every configuration change before it measures. Rates are measured as output edges counted over a window of exactly 8 output periods. The window opens and closes 1 ns after a parent edge, so an output edge that coincides with either boundary is counted the same way at both ends.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 31;
  localparam int SEL_LSB = 24;
  localparam int SEL_W   = 2;
  localparam int P_LSB   = 16;
  localparam int P_W     = 2;
  localparam int M_LSB   = 0;
  localparam int M_W     = 4;
  localparam int NUM_PAR = 1 << SEL_W;
  localparam int PCNT_W  = (1 << P_W) - 1;   // widest prescale tap count
  localparam int PH_W    = M_W + PCNT_W + 1; // holds (m+1)<<p

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [P_W-1:0]   p;
    logic [M_W-1:0]   m;
  } cfg_t;

  function automatic logic [DATA_W-1:0] cfg_pack(cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT] = c.en;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[P_LSB +: P_W] = c.p;
    w[M_LSB +: M_W] = c.m;
    return w;
  endfunction

  function automatic cfg_t cfg_unpack(logic [DATA_W-1:0] w);
    cfg_t c;
    c.en  = w[EN_BIT];
    c.sel = w[SEL_LSB +: SEL_W];
    c.p   = w[P_LSB +: P_W];
    c.m   = w[M_LSB +: M_W];
    return c;
  endfunction

  // all-ones in the low p bits: prescale terminal value
  function automatic logic [PCNT_W-1:0] pre_mask(logic [P_W-1:0] p);
    logic [PCNT_W-1:0] r;
    r = '0;
    for (int i = 0; i < PCNT_W; i++) if (i < int'(p)) r[i] = 1'b1;
    return r;
  endfunction

  // total parent cycles per output period
  function automatic logic [PH_W-1:0] div_total(logic [M_W-1:0] m, logic [P_W-1:0] p);
    logic [PH_W-1:0] base;
    base = PH_W'(m) + PH_W'(1);
    return base << p;
  endfunction

  // parent cycles the output spends high
  function automatic logic [PH_W-1:0] high_len(logic [M_W-1:0] m, logic [P_W-1:0] p);
    return div_total(m, p) >> 1;
  endfunction
endpackage

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg
  import cdiv_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 0
) (
  input  logic                bus_clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                en_o,
  output logic [M_W-1:0]      m_o,
  output logic [P_W-1:0]      p_o,
  output logic [SEL_W-1:0]    sel_app_o
);
  cfg_t cfg_q;
  cfg_t wr_cfg;
  logic hit;
  logic wr_hit;
  logic [SEL_W-1:0] sel_app;

  assign hit    = (bus_addr == ADDR_W'(REG_ADDR));
  assign wr_hit = hit && bus_we;
  assign wr_cfg = cfg_unpack(bus_wdata);

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_hit) cfg_q <= wr_cfg;
  end

  // the mux select only moves while the stored enable is clear
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) sel_app <= '0;
    else if (!cfg_q.en) sel_app <= wr_hit ? wr_cfg.sel : cfg_q.sel;
  end

  assign bus_rdata = hit ? cfg_pack(cfg_q) : '0;
  assign en_o      = cfg_q.en;
  assign m_o       = cfg_q.m;
  assign p_o       = cfg_q.p;
  assign sel_app_o = sel_app;

  // R5
  sel_hold_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    cfg_q.en |=> $stable(sel_app));

  // R9
  miss_keep_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bus_we && !hit) |=> $stable(cfg_q));
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
  import cdiv_pkg::*;
(
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [P_W-1:0]   p_i,
  output logic             en_s_o,
  output logic             div_q_o,
  output logic             bypass_o
);
  logic             en_s1, en_s;
  logic [M_W-1:0]   m_s1, m_s;
  logic [P_W-1:0]   p_s1, p_s;
  logic [M_W-1:0]   m_act;
  logic [P_W-1:0]   p_act;
  logic [PCNT_W-1:0] pcnt;
  logic [M_W-1:0]   mcnt;
  logic             div_q;

  // named events for the assertions
  logic             tick_w;
  logic             tc_w;
  logic [PH_W-1:0]  phase_w;
  logic [PH_W-1:0]  nphase_w;
  logic [PH_W-1:0]  hi_w;

  // two-flop synchronisers into the parent domain
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1 <= 1'b0; en_s <= 1'b0;
      m_s1  <= '0;   m_s  <= '0;
      p_s1  <= '0;   p_s  <= '0;
    end else begin
      en_s1 <= en_i; en_s <= en_s1;
      m_s1  <= m_i;  m_s  <= m_s1;
      p_s1  <= p_i;  p_s  <= p_s1;
    end
  end

  assign tick_w   = (pcnt == pre_mask(p_act));
  assign tc_w     = tick_w && (mcnt == m_act);
  assign phase_w  = (PH_W'(mcnt) << p_act) | PH_W'(pcnt);
  assign nphase_w = tc_w ? '0 : phase_w + PH_W'(1);
  assign hi_w     = tc_w ? high_len(m_s, p_s) : high_len(m_act, p_act);

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt  <= '0;
      mcnt  <= '0;
      m_act <= '0;
      p_act <= '0;
      div_q <= 1'b0;
    end else if (!en_s) begin
      pcnt  <= '0;
      mcnt  <= '0;
      m_act <= m_s;
      p_act <= p_s;
      div_q <= 1'b0;
    end else begin
      pcnt <= tick_w ? '0 : pcnt + PCNT_W'(1);
      if (tick_w) mcnt <= tc_w ? '0 : mcnt + M_W'(1);
      if (tc_w) begin
        m_act <= m_s;
        p_act <= p_s;
      end
      div_q <= (nphase_w < hi_w);
    end
  end

  assign en_s_o   = en_s;
  assign div_q_o  = div_q;
  assign bypass_o = (m_act == '0) && (p_act == '0);

  // R7
  ld_at_tc_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    (en_s && !tc_w) |=> ($stable(m_act) && $stable(p_act)));

  // R7
  mcnt_bound_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    mcnt <= m_act);

  // R3
  div_idle_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    !en_s |=> !div_q);

  // R2
  tc_restart_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    (en_s && tc_w) |=> (pcnt == '0 && mcnt == '0));
endmodule

// File: rtl/cdiv_gate.sv
module cdiv_gate (
  input  logic src_clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic bypass,
  input  logic div_q,
  output logic clk_out,
  output logic gate_q
);
  // gate state changes only while the parent is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else gate_q <= en_s;
  end

  assign clk_out = gate_q & (bypass ? src_clk : div_q);

  // R3
  gate_idle_chk: assert property (@(negedge src_clk) disable iff (!rst_n)
    !en_s |=> !gate_q);
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
  import cdiv_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 0
) (
  input  logic                 bus_clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [3:0]           par_clk,
  output logic                 clk_out,
  output logic                 clk_on
);
  logic             en_w;
  logic [M_W-1:0]   m_w;
  logic [P_W-1:0]   p_w;
  logic [SEL_W-1:0] sel_app;
  logic             src_clk;
  logic             en_s;
  logic             div_q;
  logic             bypass;

  cdiv_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_cfg (
    .bus_clk(bus_clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_o(en_w), .m_o(m_w),
    .p_o(p_w), .sel_app_o(sel_app)
  );

  // R4: parent mux, index equals the applied select
  assign src_clk = par_clk[sel_app];

  cdiv_core u_core (
    .src_clk(src_clk), .rst_n(rst_n), .en_i(en_w), .m_i(m_w), .p_i(p_w),
    .en_s_o(en_s), .div_q_o(div_q), .bypass_o(bypass)
  );

  cdiv_gate u_gate (
    .src_clk(src_clk), .rst_n(rst_n), .en_s(en_s), .bypass(bypass),
    .div_q(div_q), .clk_out(clk_out), .gate_q(clk_on)
  );
endmodule

// File: tb/tb_cdiv_top.sv
module tb_cdiv_top;
  logic        bus_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we   = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  par_clk = 4'b0;
  logic        clk_out, clk_on;

  int checks = 0, errors = 0, out_edges = 0;
  bit done = 0;

  always #4 bus_clk = ~bus_clk;            // 125 MHz
  always #2 par_clk[0] = ~par_clk[0];
  always #3 par_clk[1] = ~par_clk[1];
  always #5 par_clk[2] = ~par_clk[2];
  always #7 par_clk[3] = ~par_clk[3];
  always @(posedge clk_out) out_edges++;

  cdiv_top dut (.bus_clk(bus_clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .par_clk(par_clk),
    .clk_out(clk_out), .clk_on(clk_on));

  // {sel[7:6], p[5:4], m[3:0]}
  localparam logic [7:0] VEC [8] = '{
    8'h00, 8'h01, 8'h12, 8'h5F, 8'h83, 8'hA0, 8'hF7, 8'h39 };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge bus_clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_par(input int sel, input int n);
    for (int i = 0; i < n; i++)
      case (sel)
        0: @(posedge par_clk[0]);
        1: @(posedge par_clk[1]);
        2: @(posedge par_clk[2]);
        default: @(posedge par_clk[3]);
      endcase
  endtask

  task automatic measure(input int sel, input int n, output int cnt);
    int a;
    wait_par(sel, 1); #1 a = out_edges;
    wait_par(sel, n); #1 cnt = out_edges - a;
  endtask

  function automatic logic [31:0] word(input bit en, input int sel, input int p, input int m);
    return {en, 5'b0, 2'(sel), 6'b0, 2'(p), 12'b0, 4'(m)};
  endfunction

  // disable, set fields, enable, settle
  task automatic apply(input int sel, input int p, input int m);
    int d;
    d = (m + 1) * (1 << p);
    wr(8'h00, word(1'b0, sel, p, m));
    wait_par(sel, 6);
    wr(8'h00, word(1'b1, sel, p, m));
    wait_par(sel, 2 * d + 8);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int cnt, sel, p, m, d;
    #3 chk(clk_out == 1'b0, "R8 clk_out in reset", clk_out, 0);
    repeat (5) @(negedge bus_clk);
    rst_n = 1'b1;
    rd(8'h00, r);
    chk(r == 32'h0, "R8 word after reset", r, 0);
    chk(clk_out == 1'b0 && clk_on == 1'b0, "R8 outputs after reset", {clk_out, clk_on}, 0);

    // table of rate vectors: R2 R4 R6
    for (int v = 0; v < 8; v++) begin
      sel = VEC[v][7:6]; p = VEC[v][5:4]; m = VEC[v][3:0];
      d = (m + 1) * (1 << p);
      apply(sel, p, m);
      measure(sel, 8 * d, cnt);
      chk(cnt == 8, $sformatf("R2 R4 rate sel=%0d p=%0d m=%0d", sel, p, m), cnt, 8);
      if (d == 1) chk(cnt == 8, "R6 passthrough edges", cnt, 8);
      chk(clk_on == 1'b1, "R3 clk_on while enabled", clk_on, 1);
    end

    // R3: disabled output quiet
    wr(8'h00, word(1'b0, 0, 0, 1));
    wait_par(0, 10);
    measure(0, 64, cnt);
    chk(cnt == 0, "R3 no edges while disabled", cnt, 0);
    chk(clk_on == 1'b0, "R3 clk_on low while disabled", clk_on, 0);

    // R5: select write while enabled is held
    apply(0, 0, 1);
    wr(8'h00, word(1'b1, 2, 0, 1));
    wait_par(0, 20);
    measure(0, 16, cnt);
    chk(cnt == 8, "R5 parent held while enabled", cnt, 8);
    wr(8'h00, word(1'b0, 2, 0, 1));
    wait_par(2, 6);
    wr(8'h00, word(1'b1, 2, 0, 1));
    wait_par(2, 20);
    measure(2, 16, cnt);
    chk(cnt == 8, "R5 R4 new parent after disable", cnt, 8);

    // R7: divider change while running
    apply(1, 0, 3);
    wr(8'h00, word(1'b1, 1, 1, 2));
    wait_par(1, 40);
    measure(1, 48, cnt);
    chk(cnt == 8, "R7 new ratio after running change", cnt, 8);

    // R1: field layout and unused bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, r);
    chk(r == 32'h8303_000F, "R1 readback mask", r, 32'h8303_000F);
    wr(8'h00, 32'h0102_0005);
    rd(8'h00, r);
    chk(r == 32'h0102_0005, "R1 field readback", r, 32'h0102_0005);

    // R9: other addresses
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h00, r);
    chk(r == 32'h0102_0005, "R9 word kept on miss write", r, 32'h0102_0005);
    rd(8'h05, r);
    chk(r == 32'h0, "R9 miss read zero", r, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule